// File: doc/BRIEF.md
# SHA-256 Message Schedule Expander

This block builds the 64-word message schedule that the SHA-256 compression rounds consume. A host first writes the sixteen 32-bit words of one 512-bit block through a load port. It then pulses `start`. The block generates the remaining 48 words using the standard recurrence: the small sigma-1 of the word two places back, plus the word seven back, plus the small sigma-0 of the word fifteen back, plus the word sixteen back. All additions wrap modulo 2^32. Sigma-0 is the XOR of rotate-right by 7, rotate-right by 18 and shift-right by 3. Sigma-1 is the XOR of rotate-right by 17, rotate-right by 19 and shift-right by 10.

The schedule is stored in two half-depth RAM banks. One bank holds the even-indexed words and the other holds the odd-indexed words. Each bank has two synchronous read ports and one write port. Every new word needs two operands from its own bank (offsets 2 and 16) and two from the other bank (offsets 7 and 15). All four operands are therefore fetched in one cycle, and each step costs one fetch cycle plus one compute-and-write cycle.

Once `done` has pulsed, the round logic reads any of the 64 words through a one-cycle-latency read port.

Top module: `sha_sched_expander`

## Requirements
- R1: While reset is applied and in the cycle after it, `busy` and `done` are both 0.
- R2: A load with `ld_en`=1 while `busy`=0 stores `ld_word` as schedule word `ld_idx`. Word i of the block is loaded with `ld_idx`=i, for i from 0 to 15.
- R3: A read request with `rd_en`=1 while `busy`=0 places schedule word `rd_idx` on `rd_word` one cycle later. Word t is kept in the bank chosen by bit 0 of t, at bank address t>>1.
- R4: After a run, each word t from 16 to 63 equals sigma1(W[t-2]) + W[t-7] + sigma0(W[t-15]) + W[t-16] mod 2^32. Sigma-0 and sigma-1 are defined as above.
- R5: `start` sampled high while idle raises `busy` at that same edge. Over 48 steps of two cycles each, `busy` stays high for exactly 96 cycles. `done` is high in the cycle that follows, which is 96 clock edges after the edge that accepted `start`.
- R6: `done` stays high for exactly one cycle, and `busy` and `done` are never high together.
- R7: Loads presented while `busy`=1 are ignored and change no schedule word.
- R8: A `start` presented while `busy`=1 is ignored, so the run still ends 96 edges after the original start.
- R9: Words 0 to 15 keep their loaded values after a run.
- R10: After a run, loading a new block and starting again produces the schedule of the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe for one block word |
| ld_idx | input | 4 | Index (0-15) of the word being loaded |
| ld_word | input | 32 | Word value being loaded |
| start | input | 1 | Begin expanding the loaded block |
| busy | output | 1 | High while the 48 expansion steps run |
| done | output | 1 | One-cycle pulse after the last word is written |
| rd_en | input | 1 | Read request from the round logic |
| rd_idx | input | 6 | Schedule index (0-63) to read |
| rd_word | output | 32 | Read data, valid one cycle after an accepted request |

## Verification
Loads take effect at the edge that samples them. The bench therefore reads a loaded word back through the read port, driving the request on a falling edge and comparing `rd_word` at the next falling edge, one register later. A run is timed from the edge that samples `start`: `busy` is checked on every falling edge until `done` appears, and `done` must arrive after exactly 96 rising edges and drop at the next one. Disturbing loads and a second `start` are injected in the middle of a run. Their lack of effect is confirmed by the run length and by reading all 64 words back against a schedule computed in the bench.

// File: rtl/sha_sched_pkg.sv
package sha_sched_pkg;

    localparam int WORD_W      = 32;
    localparam int SCHED_LEN   = 64;
    localparam int BLOCK_WORDS = 16;
    localparam int BANKS       = 2;
    localparam int BANK_DEPTH  = SCHED_LEN / BANKS;
    localparam int IDX_W       = $clog2(SCHED_LEN);
    localparam int BANK_AW     = $clog2(BANK_DEPTH);
    localparam int LD_IDX_W    = $clog2(BLOCK_WORDS);

    // Recurrence offsets: NEAR and BASE share the target's bank, the others do not
    localparam int OFF_NEAR = 2;
    localparam int OFF_MID  = 7;
    localparam int OFF_FAR  = 15;
    localparam int OFF_BASE = 16;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [BANK_AW-1:0] baddr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MIX,
        ST_FINISH
    } phase_t;

    typedef struct packed {
        word_t near_w;  // W[t-2]
        word_t mid_w;   // W[t-7]
        word_t far_w;   // W[t-15]
        word_t base_w;  // W[t-16]
    } operands_t;

    typedef struct packed {
        logic   we;
        baddr_t addr;
        word_t  data;
    } wr_req_t;

    function automatic word_t rotr(input word_t x, input int unsigned n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t sig_lo(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sig_hi(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t next_word(input operands_t o);
        return sig_hi(o.near_w) + o.mid_w + sig_lo(o.far_w) + o.base_w;
    endfunction

    function automatic baddr_t bank_addr(input idx_t t);
        return t[IDX_W-1:1];
    endfunction

endpackage

// File: rtl/sha_sched_bank.sv
module sha_sched_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Two synchronous read ports, one write port; a read of the address
    // being written returns the old contents.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_a <= mem[raddr_a];
        rdata_b <= mem[raddr_b];
    end

endmodule

// File: rtl/sha_sched_addr.sv
module sha_sched_addr
    import sha_sched_pkg::*;
(
    input  logic                 fetch,
    input  idx_t                 cur_t,
    input  idx_t                 rd_idx,
    output baddr_t [BANKS-1:0]   ra_a,
    output baddr_t [BANKS-1:0]   ra_b
);

    idx_t back_near, back_mid, back_far, back_base;

    always_comb begin
        back_near = cur_t - idx_t'(OFF_NEAR);
        back_mid  = cur_t - idx_t'(OFF_MID);
        back_far  = cur_t - idx_t'(OFF_FAR);
        back_base = cur_t - idx_t'(OFF_BASE);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank_addr
        localparam logic PAR = 1'(b);
        logic own_bank;
        assign own_bank = (cur_t[0] == PAR);
        // Port A: near operand (own bank) or mid operand (other bank);
        // when idle it serves the round logic read.
        assign ra_a[b] = !fetch   ? bank_addr(rd_idx)
                       : own_bank ? bank_addr(back_near)
                                  : bank_addr(back_mid);
        // Port B: base operand (own bank) or far operand (other bank).
        assign ra_b[b] = !fetch   ? '0
                       : own_bank ? bank_addr(back_base)
                                  : bank_addr(back_far);
    end

endmodule

// File: rtl/sha_sched_ctrl.sv
module sha_sched_ctrl
    import sha_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic fetch,
    output logic step_we,
    output logic busy,
    output logic done,
    output idx_t cur_t
);

    localparam idx_t FIRST_T = idx_t'(BLOCK_WORDS);
    localparam idx_t LAST_T  = idx_t'(SCHED_LEN - 1);

    phase_t phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            cur_t <= FIRST_T;
        end else begin
            unique case (phase)
                ST_IDLE: begin
                    if (start) begin
                        phase <= ST_FETCH;
                        cur_t <= FIRST_T;
                    end
                end
                ST_FETCH: phase <= ST_MIX;
                ST_MIX: begin
                    if (cur_t == LAST_T) begin
                        phase <= ST_FINISH;
                    end else begin
                        phase <= ST_FETCH;
                        cur_t <= cur_t + idx_t'(1);
                    end
                end
                ST_FINISH: phase <= ST_IDLE;
                default:   phase <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fetch   = (phase == ST_FETCH);
        step_we = (phase == ST_MIX);
        busy    = fetch || step_we;
        done    = (phase == ST_FINISH);
    end

endmodule

// File: rtl/sha_sched_expander.sv
module sha_sched_expander
    import sha_sched_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_en,
    input  logic [LD_IDX_W-1:0] ld_idx,
    input  logic [WORD_W-1:0]   ld_word,
    input  logic                start,
    output logic                busy,
    output logic                done,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [WORD_W-1:0]   rd_word
);

    logic               fetch;
    logic               step_we;
    idx_t               cur_t;
    baddr_t [BANKS-1:0] ra_a;
    baddr_t [BANKS-1:0] ra_b;
    word_t              rdata_a [BANKS];
    word_t              rdata_b [BANKS];
    wr_req_t            wr      [BANKS];
    logic [BANKS-1:0]   ld_we;
    operands_t          ops;
    word_t              new_w;
    logic               rd_par;

    sha_sched_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .fetch   (fetch),
        .step_we (step_we),
        .busy    (busy),
        .done    (done),
        .cur_t   (cur_t)
    );

    sha_sched_addr u_addr (
        .fetch  (fetch),
        .cur_t  (cur_t),
        .rd_idx (rd_idx),
        .ra_a   (ra_a),
        .ra_b   (ra_b)
    );

    // Operands arrive one cycle after the fetch; cur_t is unchanged then.
    always_comb begin
        ops.near_w = rdata_a[cur_t[0]];
        ops.base_w = rdata_b[cur_t[0]];
        ops.mid_w  = rdata_a[~cur_t[0]];
        ops.far_w  = rdata_b[~cur_t[0]];
        new_w      = next_word(ops);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic PAR = 1'(b);
        logic eng_we;

        assign eng_we   = step_we && (cur_t[0] == PAR);
        assign ld_we[b] = ld_en && !busy && (ld_idx[0] == PAR);

        assign wr[b].we   = eng_we || ld_we[b];
        assign wr[b].addr = eng_we ? bank_addr(cur_t)
                                   : baddr_t'(ld_idx[LD_IDX_W-1:1]);
        assign wr[b].data = eng_we ? new_w : ld_word;

        sha_sched_bank #(
            .DATA_W (WORD_W),
            .DEPTH  (BANK_DEPTH)
        ) u_bank (
            .clk     (clk),
            .we      (wr[b].we),
            .waddr   (wr[b].addr),
            .wdata   (wr[b].data),
            .raddr_a (ra_a[b]),
            .raddr_b (ra_b[b]),
            .rdata_a (rdata_a[b]),
            .rdata_b (rdata_b[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_par <= 1'b0;
        end else if (rd_en && !busy) begin
            rd_par <= rd_idx[0];
        end
    end

    assign rd_word = rdata_a[rd_par];

endmodule

// File: rtl/sha_sched_expander_chk.sv
module sha_sched_expander_chk
    import sha_sched_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             step_we,
    input logic [BANKS-1:0] ld_we,
    input idx_t             cur_t
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_launch_by_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_load_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ld_we == '0));

    p_step_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        step_we |=> !step_we);

    p_step_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (step_we && $past(step_we, 2)) |-> (cur_t == $past(cur_t, 2) + idx_t'(1)));

endmodule

bind sha_sched_expander sha_sched_expander_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .step_we (step_we),
    .ld_we   (ld_we),
    .cur_t   (cur_t)
);

// File: tb/sha_sched_expander_test.sv
`timescale 1ns/1ps
module sha_sched_expander_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [3:0]  ld_idx;
    logic [31:0] ld_word;
    logic        start;
    logic        busy;
    logic        done;
    logic        rd_en;
    logic [5:0]  rd_idx;
    logic [31:0] rd_word;

    int checks = 0;
    int errors = 0;

    logic [31:0] blk   [16];
    logic [31:0] exp_w [64];

    always #2 clk = ~clk;

    sha_sched_expander uut (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_word (ld_word),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic build_expected();
        for (int i = 0; i < 16; i++) exp_w[i] = blk[i];
        for (int t = 16; t < 64; t++) begin
            logic [31:0] s0, s1;
            s0 = rr(exp_w[t-15], 7) ^ rr(exp_w[t-15], 18) ^ (exp_w[t-15] >> 3);
            s1 = rr(exp_w[t-2], 17) ^ rr(exp_w[t-2], 19) ^ (exp_w[t-2] >> 10);
            exp_w[t] = s1 + exp_w[t-7] + s0 + exp_w[t-16];
        end
    endtask

    task automatic read_word(input int idx, output logic [31:0] val);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_idx = 6'(idx);
        @(negedge clk);
        rd_en  = 1'b0;
        val    = rd_word;
    endtask

    task automatic load_block();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_idx  = 4'(i);
            ld_word = blk[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        build_expected();
    endtask

    task automatic check_loaded();
        for (int i = 0; i < 16; i++) begin
            logic [31:0] v;
            read_word(i, v);
            check_eq("R2/R3", $sformatf("loaded word %0d", i), v, blk[i]);
        end
    endtask

    // Runs one expansion; with disturb set, a load and a second start
    // are presented in the middle of the run.
    task automatic run_expand(input bit disturb);
        int n = 0;
        int busy_cycles = 0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check_eq("R5", "busy after start", 32'(busy), 32'd1);
        while (!done && n < 300) begin
            if (busy) busy_cycles++;
            if (disturb && (n == 10 || n == 51)) begin
                ld_en   = 1'b1;
                ld_idx  = 4'(n % 16);
                ld_word = 32'hDEAD_BEEF;
                start   = 1'b1;
            end else begin
                ld_en = 1'b0;
                start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        ld_en = 1'b0;
        start = 1'b0;
        check_eq(disturb ? "R8" : "R5", "edges from start to done", 32'(n), 32'd96);
        check_eq("R5", "busy cycles", 32'(busy_cycles), 32'd96);
        check_eq("R6", "busy low while done", 32'(busy), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check_eq("R6", "done after one cycle", 32'(done), 32'd0);
    endtask

    task automatic check_schedule(input string tag);
        for (int i = 0; i < 64; i++) begin
            logic [31:0] v;
            read_word(i, v);
            if (i < 16) check_eq("R9", $sformatf("%s word %0d", tag, i), v, exp_w[i]);
            else        check_eq("R4", $sformatf("%s word %0d", tag, i), v, exp_w[i]);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; ld_en = 1'b0; ld_idx = '0; ld_word = '0;
        start = 1'b0; rd_en = 1'b0; rd_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "busy in reset", 32'(busy), 32'd0);
        check_eq("R1", "done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "busy after reset", 32'(busy), 32'd0);
        check_eq("R1", "done after reset", 32'(done), 32'd0);
    endtask

    task automatic t_padded_abc();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0]  = 32'h6162_6380;
        blk[15] = 32'h0000_0018;
        load_block();
        check_loaded();
        run_expand(1'b0);
        read_word(16, v);
        check_eq("R4", "known word 16", v, 32'h6162_6380);
        read_word(17, v);
        check_eq("R4", "known word 17", v, 32'h000F_0000);
        check_schedule("abc");
    endtask

    task automatic t_disturbed_run();
        for (int i = 0; i < 16; i++) blk[i] = 32'(i + 1) * 32'h9E37_79B9 ^ 32'h0F0F_1234;
        load_block();
        run_expand(1'b1);
        // R7: mid-run loads targeted words 10 and 3; the readback must
        // still match the untouched block.
        check_schedule("disturbed");
    endtask

    task automatic t_reload();
        for (int i = 0; i < 16; i++) blk[i] = 32'hFFFF_FFFF;
        load_block();
        run_expand(1'b0);
        check_schedule("R10 all-ones");
        for (int i = 0; i < 16; i++) blk[i] = 32'h8000_0000 >> i;
        load_block();
        check_loaded();
        run_expand(1'b0);
        check_schedule("R10 walking-one");
    endtask

    initial begin
        t_reset();
        t_padded_abc();
        t_disturbed_run();
        t_reload();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule